// File: doc/BRIEF.md
# Switch-Programmed Cycle IRQ Counter

This block is a long-delay interrupt timer. A 30-bit counter moves forward by one on each CPU-cycle enable pulse once software has started it. When the count reaches a threshold, the block raises a level-sensitive interrupt request and stops counting. The request stays high until software acknowledges it.

Software controls the timer with a single control bit. This bit arrives on a strobe each time the associated control register is written. A zero in the bit starts the count. A one clears the count, holds it at zero and drops any pending request. The threshold comes from four board-level switch inputs. The switches sit just below a fixed top bit, so the possible delays range from 2^29 cycles up to almost 2^30 cycles.

The switch inputs are synchronised and the threshold is rebuilt from them on every cycle, so a change to a switch affects the next comparison. Power-up and soft reset both go through the synchronous reset.

Top module: `cycle_irq_timer`

## Requirements
- R1: The count is CNT_W bits wide (30 by default). It increases by exactly one on each clock edge where `cpu_tick` is high and counting is running. It does not change on edges where `cpu_tick` is low.
- R2: A control write (`ctl_wr` high) with `ctl_hold` = 0 starts counting from the current count. A write with `ctl_hold` = 0 does not clear a pending request.
- R3: A control write with `ctl_hold` = 1 sets the count to zero, stops counting and clears any pending request. `irq_o` is low after that edge.
- R4: The threshold is 2^(CNT_W-1) with the four bits of `sw` placed directly below that bit. `sw[3]` lands on bit CNT_W-2 and `sw[0]` on bit CNT_W-5. The thresholds are 0x20000000 when `sw` is 0000, 0x28000000 when it is 0100, and 0x3E000000 when it is 1111.
- R5: On the edge where the count reaches or passes the threshold, the request becomes pending and counting stops. From the moment counting starts at zero, the request appears exactly `threshold` ticks later.
- R6: `irq_o` is high exactly while a request is pending. A pending request stays set whatever happens on `cpu_tick` until an R3 write or a reset.
- R7: While `rst_n` is low at a clock edge, the count becomes zero, counting stops and the pending request clears. After reset, no request appears until counting is started by an R2 write.
- R8: If an R3 write lands on the same edge as the terminal count, the write wins and `irq_o` stays low.
- R9: A change on `sw` is reflected in the threshold within three clock cycles, and that threshold is used for comparisons during a count already in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up and soft reset) |
| cpu_tick | input | 1 | One pulse per CPU cycle; advances the count while running |
| ctl_wr | input | 1 | Strobe: the control register is being written this cycle |
| ctl_hold | input | 1 | Control bit carried with the strobe: 1 holds/acknowledges, 0 runs |
| sw | input | 4 | Switch levels; sw[3] is the first switch (highest threshold weight) |
| irq_o | output | 1 | Level-sensitive interrupt request |

## Verification
The bench uses a 12-bit counter so that a full delay fits in a short run. It measures the firing edge to the exact cycle for three switch settings. An off-by-one in the compare, or a count that advances on the start write, would move the interrupt by one cycle and be caught. It also checks several cases that a flawed design would mishandle:
- An acknowledge that lands on the terminal edge must leave the line low; a design with the wrong priority would leave it high.
- With half-rate ticks, the delay must double; a design that ignores the enable would fire early.
- A switch change in the middle of a count must pull the firing point forward; a design that latches the threshold only at start would fire late.
- A reset during a pending request must clear it and keep the timer stopped; a design that resumes after reset would fire again later.

// File: rtl/cycle_irq_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and threshold construction for the cycle IRQ timer.
// Assumes the counter is at least SW_N+2 bits wide.
package cycle_irq_pkg;
    localparam int SW_N = 4;

    // Builds the threshold: fixed top bit, switch field directly beneath it.
    function automatic logic [31:0] make_limit(input int width, input logic [SW_N-1:0] s);
        logic [31:0] v;
        v = (32'd1 << (width - 1)) | ({28'd0, s} << (width - 1 - SW_N));
        return v;
    endfunction
endpackage

// File: rtl/sw_sync.sv
`timescale 1ns/1ps
// Module: sw_sync
// Two-stage synchroniser for each slow switch level. Assumes the inputs are
// quasi-static and that per-bit synchronisation is acceptable.
module sw_sync #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] d_sync
);
    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            logic s1, s2;
            // Two flops per bit to settle metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    s1 <= 1'b0;
                    s2 <= 1'b0;
                end else begin
                    s1 <= d_async[g];
                    s2 <= s1;
                end
            end
            assign d_sync[g] = s2;
        end
    endgenerate
endmodule

// File: rtl/limit_reg.sv
`timescale 1ns/1ps
// Module: limit_reg
// Rebuilds the compare threshold from the synchronised switches on every cycle.
// Assumes W >= SW_N + 2 and W <= 32.
module limit_reg
    import cycle_irq_pkg::*;
#(
    parameter int W = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SW_N-1:0] sw_s,
    output logic [W-1:0]    limit
);
    localparam logic [W-1:0] BASE = W'(make_limit(W, '0));

    // Register the threshold so the compare path starts from a flop.
    always_ff @(posedge clk) begin
        if (!rst_n) limit <= BASE;
        else        limit <= W'(make_limit(W, sw_s));
    end
endmodule

// File: rtl/tick_counter.sv
`timescale 1ns/1ps
// Module: tick_counter
// Run/hold counter with a sticky pending flag. Control writes take priority over
// counting, so an acknowledge on the terminal edge wins. Assumes limit < 2^W.
module tick_counter #(
    parameter int W = 30
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cpu_tick,
    input  logic         ctl_wr,
    input  logic         ctl_hold,
    input  logic [W-1:0] limit,
    output logic         pending
);
    logic [W-1:0] cnt;
    logic         run;
    logic [W-1:0] cnt_nxt;

    assign cnt_nxt = cnt + 1'b1;

    // Count, start/stop and pending-flag update, write first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            run     <= 1'b0;
            pending <= 1'b0;
        end else if (ctl_wr) begin
            run <= !ctl_hold;
            if (ctl_hold) begin
                cnt     <= '0;
                pending <= 1'b0;
            end
        end else if (run && cpu_tick) begin
            cnt <= cnt_nxt;
            if (cnt_nxt >= limit) begin
                pending <= 1'b1;
                run     <= 1'b0;
            end
        end
    end

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && ctl_hold) |=> (!pending && cnt == '0 && !run)); // R3
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cpu_tick && !ctl_wr) |=> (cnt == $past(cnt) + 1'b1)); // R1
    AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_tick && !ctl_wr) |=> $stable(cnt)); // R1
    AST_STOP_ON_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pending) |-> !run); // R5
    AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !(ctl_wr && ctl_hold)) |=> pending); // R6
endmodule

// File: rtl/cycle_irq_timer.sv
`timescale 1ns/1ps
// Module: cycle_irq_timer (top)
// Long-delay interrupt timer: switch-programmed threshold, run/hold control
// bit delivered by a write strobe, level interrupt output. Synchronous
// active-low reset covers both power-up and soft reset.
module cycle_irq_timer
    import cycle_irq_pkg::*;
#(
    parameter int CNT_W = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cpu_tick,
    input  logic       ctl_wr,
    input  logic       ctl_hold,
    input  logic [3:0] sw,
    output logic       irq_o
);
    logic [SW_N-1:0]  sw_s;
    logic [CNT_W-1:0] limit;
    logic             pending;

    sw_sync #(.N(SW_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(sw), .d_sync(sw_s)
    );

    limit_reg #(.W(CNT_W)) u_limit (
        .clk(clk), .rst_n(rst_n), .sw_s(sw_s), .limit(limit)
    );

    tick_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .ctl_wr(ctl_wr),
        .ctl_hold(ctl_hold), .limit(limit), .pending(pending)
    );

    assign irq_o = pending;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !irq_o); // R7
    AST_LIMIT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        limit[CNT_W-1]); // R4
endmodule

// File: tb/cycle_irq_timer_test.sv
`timescale 1ns/1ps
module cycle_irq_timer_test;
    localparam int W = 12;
    localparam int LIM_W = 200000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cpu_tick = 1'b1;
    logic ctl_wr = 1'b0;
    logic ctl_hold = 1'b1;
    logic [3:0] sw = 4'd0;
    logic irq_o;
    logic half_rate = 1'b0;
    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cycle_irq_timer #(.CNT_W(W)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_tick(cpu_tick), .ctl_wr(ctl_wr),
        .ctl_hold(ctl_hold), .sw(sw), .irq_o(irq_o)
    );

    always @(negedge clk) cpu_tick <= half_rate ? ~cpu_tick : 1'b1;

    function automatic int limit_of(input logic [3:0] s);
        return (1 << (W - 1)) | (int'(s) << (W - 5));
    endfunction

    task automatic check(input string req, input logic exp);
        checks++;
        if (irq_o !== exp) begin
            errors++;
            $display("FAIL %s: irq_o=%0b expected %0b at %0t", req, irq_o, exp, $time);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic ctl(input logic hold);
        ctl_wr = 1'b1; ctl_hold = hold;
        @(posedge clk); @(negedge clk);
        ctl_wr = 1'b0;
    endtask

    task automatic set_sw(input logic [3:0] s);
        sw = s;
        edges(5);
    endtask

    // R4 R5: exact firing edge for a switch pattern.
    task automatic t_fire(input logic [3:0] s, input string req);
        int t;
        t = limit_of(s);
        ctl(1'b1);
        set_sw(s);
        ctl(1'b0);
        edges(t - 1);
        check(req, 1'b0);
        edges(1);
        check(req, 1'b1);
    endtask

    // R6 R2 R3: sticky request, run write does not clear, hold write does.
    task automatic t_sticky;
        edges(50);
        check("R6", 1'b1);
        ctl(1'b0);
        check("R2", 1'b1);
        ctl(1'b1);
        check("R3", 1'b0);
    endtask

    // R3: hold mid-count restarts the full delay.
    task automatic t_restart;
        int t;
        t = limit_of(4'd0);
        set_sw(4'd0);
        ctl(1'b0);
        edges(1000);
        ctl(1'b1);
        ctl(1'b0);
        edges(t - 1);
        check("R3", 1'b0);
        edges(1);
        check("R3", 1'b1);
        ctl(1'b1);
    endtask

    // R8: acknowledge on the terminal edge wins.
    task automatic t_collide;
        int t;
        t = limit_of(4'd0);
        ctl(1'b0);
        edges(t - 1);
        ctl(1'b1);
        check("R8", 1'b0);
        edges(10);
        check("R8", 1'b0);
    endtask

    // R1: half-rate ticks double the delay.
    task automatic t_half;
        int t;
        t = limit_of(4'd0);
        half_rate = 1'b1;
        edges(2);
        ctl(1'b0);
        edges(2 * t - 10);
        check("R1", 1'b0);
        edges(20);
        check("R1", 1'b1);
        half_rate = 1'b0;
        ctl(1'b1);
        edges(2);
    endtask

    // R9: lowering the threshold mid-count takes effect.
    task automatic t_swchange;
        int t;
        t = limit_of(4'd0);
        set_sw(4'hF);
        ctl(1'b0);
        edges(100);
        sw = 4'd0;
        edges(t - 100 - 8);
        check("R9", 1'b0);
        edges(16);
        check("R9", 1'b1);
        ctl(1'b1);
    endtask

    // R7: reset drops the request and leaves the timer stopped.
    task automatic t_reset;
        ctl(1'b0);
        edges(limit_of(4'd0) + 2);
        check("R7", 1'b1);
        rst_n = 1'b0;
        edges(2);
        check("R7", 1'b0);
        rst_n = 1'b1;
        edges(limit_of(4'd0) + 100);
        check("R7", 1'b0);
    endtask

    initial begin
        edges(3);
        check("R7", 1'b0);
        rst_n = 1'b1;
        edges(3);
        check("R7", 1'b0);
        t_fire(4'b0000, "R4");
        t_sticky;
        t_fire(4'b0100, "R4");
        ctl(1'b1);
        t_fire(4'b1111, "R5");
        ctl(1'b1);
        t_restart;
        t_collide;
        t_half;
        t_swchange;
        t_reset;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(LIM_W * 20);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule